// File: doc/BRIEF.md
# Ping-pong receive DMA channel for Ethernet frames

This block moves received Ethernet frames from a byte stream into memory. Memory is organised as rings of fixed-size slots. Two descriptor sets alternate as the active ring. Each set holds a base address, a count of free slots and an arm state. A frame is placed in the slot given by the active set's base address plus (slots used) times the slot size. The frame's data starts after a 16-byte header. Once the last byte has arrived, the channel writes the header into the slot, takes one slot from the set, flags the set as done and raises the interrupt.

When the active set runs out of slots, the next frame goes to the other set. The host refills the exhausted set while the other one is filling. The host first holds the channel in reset, loads and arms both sets, and then releases the channel. It acknowledges completions through each set's command register, and it can disable the channel or stop a set at any time.

The frame engine is a state machine with six states:

| State | Meaning |
|-------|---------|
| `S_HOLD` | Held in reset. This is the state after power-up. |
| `S_OFF` | Disabled. |
| `S_IDLE` | Waiting for a start of frame. |
| `S_DATA` | Storing bytes. |
| `S_SKIP` | Discarding a refused frame. |
| `S_HDR` | Writing the four header bytes. |

Transitions:

- HOLD→IDLE and OFF→IDLE happen on the run code.
- Any state goes to HOLD on the hold code and to OFF on the disable code. The hold code wins if both apply.
- IDLE→DATA on a start of frame when the active set is usable. If that first byte is also the end of frame, the state goes straight to HDR.
- IDLE→SKIP on a refused start of frame. If that first byte is also the end of frame, the state stays in IDLE.
- DATA→HDR and SKIP→IDLE on the end of frame.
- HDR→IDLE after the fourth header byte.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the status word reads 0x8000 (held), `irq` and `fr_busy` are low, and frames presented while held cause no memory write.
- R2: Writing 16'h0400 to address 0x00 starts the channel; the status then reads bit 10 set. Writing 16'h1000 disables it; frames are then ignored with no write and no error, and the status reads 0. Writing 16'h8800 holds it; this clears the error flag and both sets' armed and done flags and returns the active set to set 0.
- R3: Set s (s = 0, 1) has its registers at 0x10 + 0x10·s: base at +0x0, free-slot count at +0x4, command at +0x8. The command codes are: 16'h9800 arms the set, 16'h1100 stops it, 16'h0100 acknowledges it. A command read returns bit 15 = armed and bit 8 = done.
- R4: An accepted frame uses slot i = SLOTS − count of the active set, at address base + i·SLOT_BYTES. Data byte k is written to slot offset 16 + k, one byte per memory write, in arrival order.
- R5: After the last byte, four header bytes are written in this order, one per cycle, while `fr_busy` is high:
  - offset 0: stored length bits [7:0]
  - offset 2: {flags[3:0], length[11:8]}
  - offset 4: runt count
  - offset 6: collision count
- R6: Bytes beyond SLOT_BYTES − 16 are dropped. The header length is then SLOT_BYTES − 16, and the slot is still consumed.
- R7: A completed frame decrements the set's free count by one, sets its done flag, and sets status bit 8 and `irq`. An acknowledge clears that set's done flag, and `irq` falls once neither set is done.
- R8: When a completed frame leaves the active set with a count of 0, the next frame goes to the other set's slot 0.
- R9: A frame that starts while the active set is unarmed or has a count of 0 causes no write and no done flag. It sets status bit 13, which stays set until the hold code is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| fr_valid | input | 1 | Frame byte valid |
| fr_sof | input | 1 | First byte of frame |
| fr_eof | input | 1 | Last byte of frame |
| fr_data | input | 8 | Frame byte |
| fr_flags | input | 4 | Receive status flags, valid with the last byte |
| fr_runt | input | 8 | Runt count, valid with the last byte |
| fr_coll | input | 8 | Collision count, valid with the last byte |
| fr_busy | output | 1 | Header write in progress; the source must hold off |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_data | output | 8 | Memory write byte |
| irq | output | 1 | Interrupt: some set has an unacknowledged completion |

## Verification
The bench builds the channel with SLOTS = 4 and SLOT_BYTES = 64, so each slot carries 48 data bytes. With these values a truncated frame and a frame of exactly 48 bytes cost only a few dozen cycles each. Four frames are enough to empty set 0, which brings the switch to set 1 within reach. The default 2048-byte slots use the same length arithmetic, with a wider counter.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [2:0] {
        S_HOLD,
        S_OFF,
        S_IDLE,
        S_DATA,
        S_SKIP,
        S_HDR
    } rx_state_t;

    localparam logic [15:0] CTL_HOLD = 16'h8800;
    localparam logic [15:0] CTL_RUN  = 16'h0400;
    localparam logic [15:0] CTL_OFF  = 16'h1000;
    localparam logic [15:0] CMD_ARM  = 16'h9800;
    localparam logic [15:0] CMD_STOP = 16'h1100;
    localparam logic [15:0] CMD_ACK  = 16'h0100;

    localparam int STB_HELD = 15;
    localparam int STB_ERR  = 13;
    localparam int STB_RUN  = 10;
    localparam int STB_DONE = 8;

endpackage

// File: rtl/rxd_desc_set.sv
module rxd_desc_set
    import rxd_pkg::*;
#(
    parameter int AW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_base,
    input  logic          wr_rem,
    input  logic          wr_cmd,
    input  logic [31:0]   wdata,
    input  logic          consume,
    output logic [AW-1:0] base,
    output logic [RW-1:0] remaining,
    output logic          armed,
    output logic          done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base      <= '0;
            remaining <= '0;
            armed     <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (clr) begin
                armed <= 1'b0;
                done  <= 1'b0;
            end else begin
                if (wr_cmd) begin
                    unique case (wdata[15:0])
                        CMD_ARM:  armed <= 1'b1;
                        CMD_STOP: armed <= 1'b0;
                        CMD_ACK:  done  <= 1'b0;
                        default:  ;
                    endcase
                end
                if (consume) begin
                    remaining <= remaining - 1'b1;
                    done      <= 1'b1;
                end
            end
            if (wr_base) base <= wdata[AW-1:0];
            if (wr_rem)  remaining <= wdata[RW-1:0];
        end
    end

    // R7: a slot is only taken from a set that still has one
    a_r7_consume_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> (remaining != '0));

    // R7: a completion leaves the done flag set
    a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !clr) |=> done);

endmodule

// File: rtl/rxd_frame_fsm.sv
module rxd_frame_fsm
    import rxd_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SLOTS      = 8,
    parameter int SLOT_BYTES = 2048,
    parameter int HDR_BYTES  = 16,
    parameter int RW         = 4,
    parameter int NSETS      = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_hold,
    input  logic                     ctl_run,
    input  logic                     ctl_off,
    input  logic                     fr_valid,
    input  logic                     fr_sof,
    input  logic                     fr_eof,
    input  logic [7:0]               fr_data,
    input  logic [3:0]               fr_flags,
    input  logic [7:0]               fr_runt,
    input  logic [7:0]               fr_coll,
    input  logic [NSETS-1:0][AW-1:0] set_base,
    input  logic [NSETS-1:0][RW-1:0] set_rem,
    input  logic [NSETS-1:0]         set_armed,
    output logic [NSETS-1:0]         consume,
    output logic                     fr_busy,
    output logic                     chan_held,
    output logic                     chan_run,
    output logic                     err,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [7:0]               mem_data
);

    localparam int CNT_W   = $clog2(SLOT_BYTES);
    localparam int PAYLOAD = SLOT_BYTES - HDR_BYTES;

    rx_state_t state, state_nx;

    logic              active;
    logic              fset;
    logic [AW-1:0]     frame_addr;
    logic [CNT_W-1:0]  byte_cnt;
    logic [1:0]        hdr_idx;
    logic [3:0]        m_flags;
    logic [7:0]        m_runt;
    logic [7:0]        m_coll;

    logic              start;
    logic              usable;
    logic              ctl_any;
    logic [AW-1:0]     slot_idx;
    logic [AW-1:0]     slot_addr;
    logic [11:0]       len12;

    assign start     = fr_valid && fr_sof;
    assign usable    = set_armed[active] && (set_rem[active] != '0);
    assign ctl_any   = ctl_hold || ctl_off;
    assign slot_idx  = AW'(SLOTS) - AW'(set_rem[active]);
    assign slot_addr = set_base[active] + slot_idx * AW'(SLOT_BYTES);
    assign len12     = 12'(byte_cnt);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_HOLD;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_HOLD: if (ctl_run) state_nx = S_IDLE;
            S_OFF:  if (ctl_run) state_nx = S_IDLE;
            S_IDLE: begin
                if (start) begin
                    if (usable) state_nx = fr_eof ? S_HDR  : S_DATA;
                    else        state_nx = fr_eof ? S_IDLE : S_SKIP;
                end
            end
            S_DATA: if (fr_valid && fr_eof) state_nx = S_HDR;
            S_SKIP: if (fr_valid && fr_eof) state_nx = S_IDLE;
            S_HDR:  if (hdr_idx == 2'd3)    state_nx = S_IDLE;
            default: state_nx = S_HOLD;
        endcase
        if (ctl_off)  state_nx = S_OFF;
        if (ctl_hold) state_nx = S_HOLD;
    end

    // outputs decoded from state
    always_comb begin
        fr_busy   = (state == S_HDR);
        chan_held = (state == S_HOLD);
        chan_run  = (state != S_HOLD) && (state != S_OFF);
        consume   = '0;
        if (state == S_HDR && hdr_idx == 2'd3 && !ctl_any) consume[fset] = 1'b1;
    end

    // datapath and memory port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active     <= 1'b0;
            fset       <= 1'b0;
            frame_addr <= '0;
            byte_cnt   <= '0;
            hdr_idx    <= '0;
            m_flags    <= '0;
            m_runt     <= '0;
            m_coll     <= '0;
            err        <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_data   <= '0;
        end else begin
            mem_we <= 1'b0;
            if (ctl_hold) begin
                err    <= 1'b0;
                active <= 1'b0;
            end else if (!ctl_off) begin
                if (fr_valid && fr_eof) begin
                    m_flags <= fr_flags;
                    m_runt  <= fr_runt;
                    m_coll  <= fr_coll;
                    hdr_idx <= '0;
                end
                unique case (state)
                    S_IDLE: begin
                        if (start && usable) begin
                            frame_addr <= slot_addr;
                            fset       <= active;
                            byte_cnt   <= CNT_W'(1);
                            mem_we     <= 1'b1;
                            mem_addr   <= slot_addr + AW'(HDR_BYTES);
                            mem_data   <= fr_data;
                        end else if (start) begin
                            err <= 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (fr_valid && (byte_cnt < CNT_W'(PAYLOAD))) begin
                            byte_cnt <= byte_cnt + 1'b1;
                            mem_we   <= 1'b1;
                            mem_addr <= frame_addr + AW'(HDR_BYTES) + AW'(byte_cnt);
                            mem_data <= fr_data;
                        end
                    end
                    S_HDR: begin
                        mem_we   <= 1'b1;
                        mem_addr <= frame_addr + AW'({hdr_idx, 1'b0});
                        unique case (hdr_idx)
                            2'd0: mem_data <= len12[7:0];
                            2'd1: mem_data <= {m_flags, len12[11:8]};
                            2'd2: mem_data <= m_runt;
                            default: mem_data <= m_coll;
                        endcase
                        hdr_idx <= hdr_idx + 1'b1;
                        if (hdr_idx == 2'd3 && fset == active && set_rem[fset] == RW'(1))
                            active <= ~active;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: every byte written stays inside the slot of the current frame
    a_r6_write_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr - frame_addr) < AW'(SLOT_BYTES)));

    // R5: the end of a stored frame is followed by the busy header phase
    a_r5_busy_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && fr_valid && fr_eof && !ctl_any) |=> fr_busy);

    // R9: the error flag only rises on a start of frame
    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(fr_valid && fr_sof));

endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
    import rxd_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SLOTS      = 8,
    parameter int SLOT_BYTES = 2048,
    parameter int HDR_BYTES  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [7:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          fr_valid,
    input  logic          fr_sof,
    input  logic          fr_eof,
    input  logic [7:0]    fr_data,
    input  logic [3:0]    fr_flags,
    input  logic [7:0]    fr_runt,
    input  logic [7:0]    fr_coll,
    output logic          fr_busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data,
    output logic          irq
);

    localparam int NSETS = 2;
    localparam int RW    = $clog2(SLOTS + 1);

    logic ctl_sel, ctl_hold, ctl_run, ctl_off;
    logic chan_held, chan_run, err;

    logic [NSETS-1:0][AW-1:0] set_base;
    logic [NSETS-1:0][RW-1:0] set_rem;
    logic [NSETS-1:0]         set_armed;
    logic [NSETS-1:0]         set_done;
    logic [NSETS-1:0]         consume;

    assign ctl_sel  = reg_wr && (reg_addr == 8'h00);
    assign ctl_hold = ctl_sel && (reg_wdata[15:0] == CTL_HOLD);
    assign ctl_run  = ctl_sel && (reg_wdata[15:0] == CTL_RUN);
    assign ctl_off  = ctl_sel && (reg_wdata[15:0] == CTL_OFF);

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        logic sel;
        assign sel = reg_wr && (reg_addr[7:4] == 4'(s + 1));
        rxd_desc_set #(.AW(AW), .RW(RW)) u_set (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (ctl_hold),
            .wr_base   (sel && reg_addr[3:0] == 4'h0),
            .wr_rem    (sel && reg_addr[3:0] == 4'h4),
            .wr_cmd    (sel && reg_addr[3:0] == 4'h8),
            .wdata     (reg_wdata),
            .consume   (consume[s]),
            .base      (set_base[s]),
            .remaining (set_rem[s]),
            .armed     (set_armed[s]),
            .done      (set_done[s])
        );
    end

    rxd_frame_fsm #(
        .AW(AW), .SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES),
        .HDR_BYTES(HDR_BYTES), .RW(RW), .NSETS(NSETS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_hold  (ctl_hold),
        .ctl_run   (ctl_run),
        .ctl_off   (ctl_off),
        .fr_valid  (fr_valid),
        .fr_sof    (fr_sof),
        .fr_eof    (fr_eof),
        .fr_data   (fr_data),
        .fr_flags  (fr_flags),
        .fr_runt   (fr_runt),
        .fr_coll   (fr_coll),
        .set_base  (set_base),
        .set_rem   (set_rem),
        .set_armed (set_armed),
        .consume   (consume),
        .fr_busy   (fr_busy),
        .chan_held (chan_held),
        .chan_run  (chan_run),
        .err       (err),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data)
    );

    assign irq = |set_done;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == 8'h00) begin
            reg_rdata[STB_HELD] = chan_held;
            reg_rdata[STB_ERR]  = err;
            reg_rdata[STB_RUN]  = chan_run;
            reg_rdata[STB_DONE] = |set_done;
        end
        for (int s = 0; s < NSETS; s++) begin
            if (reg_addr[7:4] == 4'(s + 1)) begin
                unique case (reg_addr[3:0])
                    4'h0: reg_rdata = 32'(set_base[s]);
                    4'h4: reg_rdata = 32'(set_rem[s]);
                    4'h8: begin
                        reg_rdata[15] = set_armed[s];
                        reg_rdata[8]  = set_done[s];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: the interrupt only rises after a completed frame
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|consume));

endmodule

// File: tb/rx_ring_dma_tb_top.sv
module rx_ring_dma_tb_top;

    localparam int AW    = 32;
    localparam int SLOTS = 4;
    localparam int SB    = 64;
    localparam int PAY   = SB - 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          fr_valid = 1'b0, fr_sof = 1'b0, fr_eof = 1'b0;
    logic [7:0]    fr_data = '0;
    logic [3:0]    fr_flags = '0;
    logic [7:0]    fr_runt = '0, fr_coll = '0;
    logic          fr_busy, mem_we, irq;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;

    always #2 clk = ~clk;

    rx_ring_dma #(.AW(AW), .SLOTS(SLOTS), .SLOT_BYTES(SB), .HDR_BYTES(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fr_valid(fr_valid),
        .fr_sof(fr_sof), .fr_eof(fr_eof), .fr_data(fr_data), .fr_flags(fr_flags),
        .fr_runt(fr_runt), .fr_coll(fr_coll), .fr_busy(fr_busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
    );

    int compared = 0;
    int mismatched = 0;
    logic [AW-1:0] exp_addr[$];
    logic [7:0]    exp_data[$];
    string         exp_tag[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected writes as the design produces them
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            compared++;
            if (exp_addr.size() == 0) begin
                mismatched++;
                $display("FAIL R1/R2/R9 unexpected write actual=0x%0h:0x%0h expected=none",
                         mem_addr, mem_data);
            end else begin
                automatic logic [AW-1:0] ea = exp_addr.pop_front();
                automatic logic [7:0]    ed = exp_data.pop_front();
                automatic string         et = exp_tag.pop_front();
                if (mem_addr !== ea || mem_data !== ed) begin
                    mismatched++;
                    $display("FAIL %s write actual=0x%0h:0x%0h expected=0x%0h:0x%0h",
                             et, mem_addr, mem_data, ea, ed);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // driver: pushes the expected writes, then streams the frame
    task automatic send(input int n, input logic [7:0] seed, input logic [3:0] fl,
                        input logic [7:0] ru, input logic [7:0] co,
                        input bit stored, input logic [AW-1:0] slot);
        if (stored) begin
            automatic int kept = (n < PAY) ? n : PAY;
            for (int k = 0; k < kept; k++) begin
                exp_addr.push_back(slot + 16 + k);
                exp_data.push_back(seed + 8'(k));
                exp_tag.push_back((n > PAY) ? "R6 data" : "R4 data");
            end
            exp_addr.push_back(slot);     exp_data.push_back(8'(kept));      exp_tag.push_back("R5 len");
            exp_addr.push_back(slot + 2); exp_data.push_back({fl, 4'(kept >> 8)}); exp_tag.push_back("R5 flags");
            exp_addr.push_back(slot + 4); exp_data.push_back(ru);            exp_tag.push_back("R5 runt");
            exp_addr.push_back(slot + 6); exp_data.push_back(co);            exp_tag.push_back("R5 coll");
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            fr_valid = 1'b1; fr_sof = (k == 0); fr_eof = (k == n - 1);
            fr_data = seed + 8'(k); fr_flags = fl; fr_runt = ru; fr_coll = co;
        end
        @(negedge clk);
        fr_valid = 1'b0; fr_sof = 1'b0; fr_eof = 1'b0;
        while (fr_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    logic [31:0] v;
    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00, v); chk("R1 status after reset", v, 32'h8000);
        chk("R1 irq after reset", 32'(irq), 0);
        chk("R1 busy after reset", 32'(fr_busy), 0);
        send(4, 8'h55, 4'h1, 8'h0, 8'h0, 1'b0, '0);          // R1: ignored while held

        // program both sets while held, as a host would
        wr(8'h10, 32'h1000); wr(8'h14, SLOTS); wr(8'h18, 32'h9800);
        wr(8'h20, 32'h2000); wr(8'h24, SLOTS); wr(8'h28, 32'h9800);
        rd(8'h18, v); chk("R3 set0 armed readback", v, 32'h8000);
        rd(8'h24, v); chk("R3 set1 count readback", v, SLOTS);
        rd(8'h20, v); chk("R3 set1 base readback", v, 32'h2000);
        wr(8'h00, 32'h0400);
        rd(8'h00, v); chk("R2 status running", v, 32'h0400);

        send(5, 8'hA0, 4'h3, 8'h11, 8'h22, 1'b1, 32'h1000);  // R4 R5
        rd(8'h14, v); chk("R7 set0 count after frame", v, 3);
        chk("R7 irq after frame", 32'(irq), 1);
        rd(8'h00, v); chk("R7 status done", v, 32'h0500);
        rd(8'h18, v); chk("R3 set0 cmd done readback", v, 32'h8100);
        wr(8'h18, 32'h0100);
        chk("R7 irq cleared by ack", 32'(irq), 0);
        rd(8'h18, v); chk("R7 set0 still armed after ack", v, 32'h8000);

        send(60, 8'h00, 4'hF, 8'h01, 8'h02, 1'b1, 32'h1040); // R6 truncation
        rd(8'h14, v); chk("R6 slot consumed", v, 2);
        send(1, 8'h77, 4'h0, 8'h03, 8'h04, 1'b1, 32'h1080);  // single byte
        send(PAY, 8'h10, 4'h8, 8'h05, 8'h06, 1'b1, 32'h10C0); // exact fit
        rd(8'h14, v); chk("R8 set0 exhausted", v, 0);
        send(3, 8'hC0, 4'h2, 8'h07, 8'h08, 1'b1, 32'h2000);  // R8 other set
        rd(8'h24, v); chk("R8 set1 count", v, 3);
        rd(8'h28, v); chk("R8 set1 done", v, 32'h8100);
        wr(8'h18, 32'h0100); wr(8'h28, 32'h0100);
        chk("R7 irq low after both acks", 32'(irq), 0);

        wr(8'h00, 32'h1000);
        rd(8'h00, v); chk("R2 status disabled", v, 32'h0000);
        send(4, 8'h33, 4'h1, 8'h0, 8'h0, 1'b0, '0);
        rd(8'h00, v); chk("R2 disabled frame left no error", v, 32'h0000);
        rd(8'h24, v); chk("R2 disabled frame kept count", v, 3);
        wr(8'h00, 32'h0400);

        wr(8'h28, 32'h1100);
        rd(8'h28, v); chk("R3 stop disarms", v, 32'h0000);
        send(4, 8'h44, 4'h1, 8'h0, 8'h0, 1'b0, '0);
        rd(8'h00, v); chk("R9 error after drop", v, 32'h2400);
        rd(8'h24, v); chk("R9 drop kept count", v, 3);
        chk("R9 no irq on drop", 32'(irq), 0);

        wr(8'h28, 32'h9800);
        wr(8'h00, 32'h8800);
        rd(8'h00, v); chk("R2 hold clears error", v, 32'h8000);
        rd(8'h28, v); chk("R2 hold disarms set1", v, 32'h0000);

        repeat (4) @(negedge clk);
        chk("R4 all expected writes seen", 32'(exp_addr.size()), 0);
        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule